// File: doc/BRIEF.md
# Infrared Remote Pulse Receiver

This block takes the demodulated output of an infrared receiver module and turns it into a captured bit string. Carrier present is logic 1 (a mark) and carrier absent is logic 0 (a space). The raw input is first cleaned by a noise filter that runs on a slow sample tick. The filter lets a level change through only after the new level has held for a programmable number of ticks. The filtered waveform is then measured in ticks. An optional leading guide pulse is validated first. After that, every space between two marks becomes one data bit: a long space gives 1 and a short space gives 0.

A frame has no fixed length. It ends when the line stays silent for a programmed number of ticks, so one format can arrive with any number of bits. At that point the receiver publishes three results: the shifted-in bits, the bit count and an overflow flag. It also pulses a frame-done interrupt. On the first mark seen while idle, it pulses a wake request, so that a system holding in a low-power state, with only the slow tick running, can resume. Configuration inputs select the guide format, the guide length, the 0/1 decision threshold, the silence limit and the filter depth.

Top module: `ir_pulse_rx`

## Requirements
- R1: A change of the raw input reaches the decoder only after the input has held the new level for depth+1 consecutive ticks (cfg_filt_depth_i = 0..3 gives 1..4 ticks). A shorter excursion is discarded and starts no frame.
- R2: With cfg_guide_mode_i = 0 there is no guide. The first filtered mark starts the frame, and each space that is followed by a mark yields one bit.
- R3: With cfg_guide_mode_i = 1 (half-clock guide), the frame needs a guide mark of at least cfg_guide_len_i ticks, followed by a guide space of at least cfg_guide_len_i/2 ticks, before any data is taken.
- R4: With cfg_guide_mode_i = 2 (full-clock guide), both the guide mark and the guide space must last at least cfg_guide_len_i ticks.
- R5: A data space longer than cfg_one_thresh_i ticks decodes as 1. A space of cfg_one_thresh_i ticks or less decodes as 0. Bits shift in at bit 0, so the first bit received ends up at the highest occupied position.
- R6: A frame ends on the tick where a space reaches cfg_idle_limit_i ticks. If at least one bit was captured, done_irq_o is high for exactly one clock after that tick, and rx_data_o, rx_count_o and rx_ovf_o update in the same clock.
- R7: Frames of the same format with different bit counts are all accepted, and rx_count_o reports the number of bits captured.
- R8: At most DATA_W (64) bits are kept. Any further bits are dropped and set rx_ovf_o, and rx_count_o then reads 64.
- R9: A guide mark or guide space that is too short returns the receiver to idle. No done pulse is raised and the previous results are left unchanged.
- R10: wake_req_o pulses for one clock when a filtered mark begins while the receiver is idle.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_raw_i | input | 1 | Demodulated receiver signal, 1 = carrier |
| tick_i | input | 1 | One-clock sample strobe, the unit of all lengths |
| cfg_filt_depth_i | input | 2 | Filter hold length minus one, in ticks |
| cfg_guide_mode_i | input | 2 | 0 none, 1 half-clock guide, 2 full-clock guide |
| cfg_guide_len_i | input | 8 | Minimum guide mark length in ticks |
| cfg_one_thresh_i | input | 8 | Space length above which a bit is 1 |
| cfg_idle_limit_i | input | 8 | Silence length that ends a frame |
| rx_data_o | output | 64 | Captured bits of the last completed frame |
| rx_count_o | output | 7 | Bits captured in the last completed frame |
| rx_ovf_o | output | 1 | Last frame carried more than 64 bits |
| done_irq_o | output | 1 | One-clock frame-complete pulse |
| wake_req_o | output | 1 | One-clock pulse when a frame starts |

## Verification
Every length is counted in ticks. A raw edge reaches the decoder on the (depth+1)-th tick after it, and a result or pulse is registered on that tick's clock edge. The bench therefore drives the input just after a tick and samples on the falling clock edge that follows the tick it counted. For every completed frame, it confirms that done_irq_o is still low after depth+limit-1 ticks of trailing silence, and high one tick later. Wake pulses and done pulses are also tallied continuously, and each tally is compared only once the frame's silence has run out.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GMARK,
        ST_GSPACE,
        ST_DMARK,
        ST_DSPACE
    } rx_state_e;

    localparam logic [1:0] GUIDE_NONE = 2'd0;
    localparam logic [1:0] GUIDE_HALF = 2'd1;
    localparam logic [1:0] GUIDE_FULL = 2'd2;
endpackage

// File: rtl/ir_noise_filter.sv
module ir_noise_filter #(
    parameter int FILT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_i,
    input  logic              tick_i,
    input  logic [FILT_W-1:0] depth_i,
    output logic              level_o,
    output logic              rise_o,
    output logic              fall_o
);
    typedef struct packed {
        logic [1:0]        sync;
        logic              lvl;
        logic [FILT_W-1:0] cnt;
    } filt_t;

    filt_t d, q;
    logic  change;

    always_comb begin
        d      = q;
        change = 1'b0;
        d.sync = {q.sync[0], raw_i};
        if (tick_i) begin
            if (q.sync[1] != q.lvl) begin
                if (q.cnt == depth_i) begin
                    change = 1'b1;
                    d.lvl  = ~q.lvl;
                    d.cnt  = '0;
                end else begin
                    d.cnt = q.cnt + FILT_W'(1);
                end
            end else begin
                d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign level_o = q.lvl;
    assign rise_o  = change & ~q.lvl;
    assign fall_o  = change &  q.lvl;

    // R1: the filtered level moves only on a sample tick
    p_level_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(level_o));
endmodule

// File: rtl/ir_frame_decoder.sv
module ir_frame_decoder
    import ir_rx_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int TCNT_W = 8,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic [1:0]        guide_mode_i,
    input  logic [TCNT_W-1:0] guide_len_i,
    input  logic [TCNT_W-1:0] one_thresh_i,
    input  logic [TCNT_W-1:0] idle_limit_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_o,
    output logic              done_o,
    output logic              wake_o
);
    localparam logic [TCNT_W-1:0] SEG_MAX = '1;
    localparam logic [CNT_W-1:0]  FULL    = CNT_W'(DATA_W);

    typedef struct packed {
        rx_state_e         state;
        logic [TCNT_W-1:0] seg;
        logic [DATA_W-1:0] shift;
        logic [CNT_W-1:0]  nbits;
        logic              ovf;
        logic [DATA_W-1:0] res_data;
        logic [CNT_W-1:0]  res_count;
        logic              res_ovf;
        logic              done;
        logic              wake;
    } dec_t;

    dec_t              d, q;
    logic              any_edge;
    logic              timeout;
    logic [TCNT_W-1:0] seg_inc;
    logic [TCNT_W-1:0] gspace_min;
    logic              bit_val;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.wake     = 1'b0;
        any_edge   = rise_i | fall_i;
        seg_inc    = (q.seg == SEG_MAX) ? q.seg : q.seg + TCNT_W'(1);
        timeout    = tick_i && !any_edge && (seg_inc >= idle_limit_i);
        gspace_min = guide_mode_i[1] ? guide_len_i : (guide_len_i >> 1);
        bit_val    = (q.seg > one_thresh_i);
        if (tick_i) d.seg = any_edge ? TCNT_W'(1) : seg_inc;

        unique case (q.state)
            ST_IDLE: if (rise_i) begin
                d.wake  = 1'b1;
                d.shift = '0;
                d.nbits = '0;
                d.ovf   = 1'b0;
                d.state = (guide_mode_i == GUIDE_NONE) ? ST_DMARK : ST_GMARK;
            end
            ST_GMARK: if (fall_i) begin
                d.state = (q.seg >= guide_len_i) ? ST_GSPACE : ST_IDLE;
            end
            ST_GSPACE: begin
                if (rise_i)       d.state = (q.seg >= gspace_min) ? ST_DMARK : ST_IDLE;
                else if (timeout) d.state = ST_IDLE;
            end
            ST_DMARK: if (fall_i) d.state = ST_DSPACE;
            ST_DSPACE: begin
                if (rise_i) begin
                    if (q.nbits == FULL) begin
                        d.ovf = 1'b1;
                    end else begin
                        d.shift = {q.shift[DATA_W-2:0], bit_val};
                        d.nbits = q.nbits + CNT_W'(1);
                    end
                    d.state = ST_DMARK;
                end else if (timeout) begin
                    if (q.nbits != '0) begin
                        d.done      = 1'b1;
                        d.res_data  = q.shift;
                        d.res_count = q.nbits;
                        d.res_ovf   = q.ovf;
                    end
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign data_o  = q.res_data;
    assign count_o = q.res_count;
    assign ovf_o   = q.res_ovf;
    assign done_o  = q.done;
    assign wake_o  = q.wake;

    // R6: a done pulse always reports at least one bit
    p_done_has_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (count_o != '0));
    // R8: overflow only with a full register
    p_ovf_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (count_o == FULL));
    // R8: the working bit count never passes the register size
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.nbits <= FULL);
    // R9: published results change only together with a done pulse
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> done_o);
    // R10: frame start and frame end never share a clock
    p_done_wake_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, wake_o}));
endmodule

// File: rtl/ir_pulse_rx.sv
module ir_pulse_rx #(
    parameter int DATA_W = 64,
    parameter int TCNT_W = 8,
    parameter int FILT_W = 2,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_raw_i,
    input  logic              tick_i,
    input  logic [FILT_W-1:0] cfg_filt_depth_i,
    input  logic [1:0]        cfg_guide_mode_i,
    input  logic [TCNT_W-1:0] cfg_guide_len_i,
    input  logic [TCNT_W-1:0] cfg_one_thresh_i,
    input  logic [TCNT_W-1:0] cfg_idle_limit_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic [CNT_W-1:0]  rx_count_o,
    output logic              rx_ovf_o,
    output logic              done_irq_o,
    output logic              wake_req_o
);
    logic flt_level, flt_rise, flt_fall;

    ir_noise_filter #(.FILT_W(FILT_W)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (ir_raw_i),
        .tick_i  (tick_i),
        .depth_i (cfg_filt_depth_i),
        .level_o (flt_level),
        .rise_o  (flt_rise),
        .fall_o  (flt_fall)
    );

    ir_frame_decoder #(.DATA_W(DATA_W), .TCNT_W(TCNT_W), .CNT_W(CNT_W)) u_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .rise_i       (flt_rise),
        .fall_i       (flt_fall),
        .guide_mode_i (cfg_guide_mode_i),
        .guide_len_i  (cfg_guide_len_i),
        .one_thresh_i (cfg_one_thresh_i),
        .idle_limit_i (cfg_idle_limit_i),
        .data_o       (rx_data_o),
        .count_o      (rx_count_o),
        .ovf_o        (rx_ovf_o),
        .done_o       (done_irq_o),
        .wake_o       (wake_req_o)
    );

    // R1: edges reported by the filter agree with its level
    p_edge_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flt_rise |=> flt_level);
endmodule

// File: tb/tb_ir_pulse_rx.sv
module tb_ir_pulse_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raw = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  depth = 2'd1;
    logic [1:0]  gmode = 2'd0;
    logic [7:0]  glen = 8'd16;
    logic [7:0]  thr = 8'd8;
    logic [7:0]  idle = 8'd20;
    logic [63:0] rx_data;
    logic [6:0]  rx_count;
    logic        rx_ovf, done_irq, wake_req;

    int checks = 0, failures = 0;
    int done_seen = 0, wake_seen = 0;
    int cyc = 0;
    int unsigned seed = 32'h5EED_1234;
    bit finished = 1'b0;
    logic [1:0] div = 2'd0;

    ir_pulse_rx dut (
        .clk(clk), .rst_n(rst_n), .ir_raw_i(raw), .tick_i(tick),
        .cfg_filt_depth_i(depth), .cfg_guide_mode_i(gmode), .cfg_guide_len_i(glen),
        .cfg_one_thresh_i(thr), .cfg_idle_limit_i(idle),
        .rx_data_o(rx_data), .rx_count_o(rx_count), .rx_ovf_o(rx_ovf),
        .done_irq_o(done_irq), .wake_req_o(wake_req)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        div  = div + 2'd1;
        tick = (div == 2'd0);
        if (done_irq) done_seen++;
        if (wake_req) wake_seen++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000 && !finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired act=%0d exp=<190000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic pass_ticks(input int n);
        for (int i = 0; i < n; i++) @(posedge clk iff tick);
        @(negedge clk);
    endtask

    task automatic seg(input logic lvl, input int len);
        raw = lvl;
        pass_ticks(len);
    endtask

    function automatic int mark_len();
        return 4 + int'($urandom % 3);
    endfunction

    // Sends a frame; exact=1 uses spaces of exactly thr (0) and thr+1 (1).
    // Checks the done timing when a done pulse is expected.
    task automatic send_frame(input int mode, input int gmark, input int gspace,
                              input int n, input logic [79:0] bits, input bit exact,
                              input bit expect_done, input string req);
        int n_ticks;
        if (mode != 0) begin
            seg(1'b1, gmark);
            seg(1'b0, gspace);
        end
        for (int i = 0; i < n; i++) begin
            seg(1'b1, mark_len());
            if (bits[i]) n_ticks = exact ? int'(thr) + 1 : int'(thr) + 1 + int'($urandom % 5);
            else         n_ticks = exact ? int'(thr) : 4 + int'($urandom % (int'(thr) - 3));
            seg(1'b0, n_ticks);
        end
        seg(1'b1, mark_len());
        raw = 1'b0;
        if (expect_done) begin
            pass_ticks(int'(depth) + int'(idle) - 1);
            check(done_irq == 1'b0, {req, " R6 done not early"}, 64'(done_irq), 64'd0);
            pass_ticks(1);
            check(done_irq == 1'b1, {req, " R6 done on limit tick"}, 64'(done_irq), 64'd1);
            pass_ticks(2);
        end else begin
            pass_ticks(int'(depth) + int'(idle) + 2);
        end
    endtask

    function automatic logic [63:0] exp_data(input int n, input logic [79:0] bits);
        logic [63:0] e = '0;
        for (int i = 0; i < n && i < 64; i++) e = {e[62:0], bits[i]};
        return e;
    endfunction

    task automatic frame_and_check(input int mode, input int n, input logic [79:0] bits,
                                   input bit exact, input string req);
        int d0, w0, gm, gs;
        d0 = done_seen;
        w0 = wake_seen;
        gm = int'(glen) + int'($urandom % 3);
        gs = (mode == 2) ? int'(glen) + int'($urandom % 3) : int'(glen) / 2 + int'($urandom % 3);
        gmode = 2'(mode);
        send_frame(mode, gm, gs, n, bits, exact, 1'b1, req);
        check(rx_data == exp_data(n, bits), {req, " data"}, rx_data, exp_data(n, bits));
        check(int'(rx_count) == ((n > 64) ? 64 : n), {req, " R7 count"},
              64'(rx_count), 64'((n > 64) ? 64 : n));
        check(rx_ovf == (n > 64), {req, " R8 overflow flag"}, 64'(rx_ovf), 64'(n > 64));
        check(done_seen == d0 + 1, {req, " R6 one done"}, 64'(done_seen), 64'(d0 + 1));
        check(wake_seen == w0 + 1, {req, " R10 one wake"}, 64'(wake_seen), 64'(w0 + 1));
    endtask

    initial begin
        logic [79:0] rb;
        logic [63:0] keep_data;
        int d0, w0, n, mode;
        void'($urandom(seed));
        repeat (5) @(negedge clk);
        // R11: reset state
        check(rx_data == 0 && rx_count == 0 && !rx_ovf && !done_irq && !wake_req,
              "R11 reset outputs", {rx_data[55:0], rx_count, rx_ovf}, 64'd0);
        rst_n = 1'b1;
        pass_ticks(3);

        // R1: a pulse of depth ticks (one short) is dropped; depth+1 ticks passes
        depth = 2'd1;
        gmode = 2'd0;
        w0 = wake_seen;
        d0 = done_seen;
        seg(1'b1, 1);
        seg(1'b0, 10);
        check(wake_seen == w0, "R1 short glitch rejected", 64'(wake_seen), 64'(w0));
        seg(1'b1, 2);
        seg(1'b0, 25);
        check(wake_seen == w0 + 1, "R1 R10 held pulse passes and wakes", 64'(wake_seen), 64'(w0 + 1));
        check(done_seen == d0, "R6 no done without bits", 64'(done_seen), 64'(d0));

        // R2 R5: directed frame, no guide
        frame_and_check(0, 8, 80'hA5, 1'b0, "R2 directed no guide");
        // R5: exact threshold boundary: bits 1,0,1,0 -> spaces thr+1, thr
        frame_and_check(0, 4, 80'h5, 1'b1, "R5 threshold boundary");
        // R3 / R4 directed
        frame_and_check(1, 12, 80'hC3A, 1'b0, "R3 half guide");
        frame_and_check(2, 12, 80'h35C, 1'b0, "R4 full guide");
        // R8: exactly 64 bits, then 70 bits
        frame_and_check(2, 64, {16'h0, 64'hDEAD_BEEF_0123_4567}, 1'b0, "R8 exactly full");
        frame_and_check(0, 70, {16'h3F, 64'h8888_1111_F0F0_0F0F}, 1'b0, "R8 overflow");

        // R9: guide mismatches leave results unchanged
        keep_data = rx_data;
        d0 = done_seen;
        gmode = 2'd2;
        send_frame(2, int'(glen) - 4, int'(glen), 6, 80'h2D, 1'b0, 1'b0, "R9");
        check(done_seen == d0, "R9 short guide mark no done", 64'(done_seen), 64'(d0));
        check(rx_data == keep_data, "R9 short guide mark data kept", rx_data, keep_data);
        send_frame(2, int'(glen), int'(glen) / 2 + 1, 6, 80'h2D, 1'b0, 1'b0, "R9");
        check(done_seen == d0, "R9 half space on full guide no done", 64'(done_seen), 64'(d0));
        check(rx_count == 7'd64, "R9 count kept", 64'(rx_count), 64'd64);

        // R7: random frames of varying format, length and filter depth
        for (int k = 0; k < 10; k++) begin
            rb    = {16'($urandom), $urandom, $urandom};
            mode  = int'($urandom % 3);
            n     = (k == 3) ? 72 : 1 + int'($urandom % 40);
            depth = 2'($urandom % 4);
            pass_ticks(4);
            frame_and_check(mode, n, rb, 1'b0,
                            (mode == 0) ? "R7 R2 random" : (mode == 1) ? "R7 R3 random" : "R7 R4 random");
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule